// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable behavioural model of a single-port synchronous SRAM. Every command is sampled on a rising clock edge, and the data that belongs to it moves two enabled edges later. Because of this fixed spacing, a controller can issue reads and writes in any order on consecutive cycles and the data bus never needs an idle cycle to turn around. The data bus is split into a write-data input, a read-data output and a read-data-valid flag.

A command either loads a new address or advances an internal four-beat burst. The burst can step in linear order or in interleaved order. Each word is 36 bits wide and is made of four 9-bit byte lanes, and each lane has its own active-low write enable. The block also has a clock enable that freezes all of its state, three chip selects that start a deselect cycle, and an asynchronous output enable. If a read targets a word whose write is still in the pipeline, the read returns the newer data for each byte lane.

Top module: `zbt_sram`

## Requirements
- R1: The address and command are sampled on one enabled rising edge. For a write, `wdata` is sampled on the second enabled edge after that, and only the byte lanes that were selected are written into the array.
- R2: For a read, the data sits in the output register after the second enabled edge that follows the command. `rdata_oe` is high only in the cycle after that edge, and only while `oe_n` is low.
- R3: A write followed by a read, or a read followed by a write, is accepted on consecutive cycles. The read data comes out with no gap cycle.
- R4: Byte lane i is bits [9i+8:9i] of the word. `bw_n[i]` = 0 selects lane i for a write. The byte enables are sampled with each write command and with each write burst beat.
- R5: `bw_n` has no effect when `rd_wr` = 1 (read), and the array contents do not change.
- R6: While `cke_n` = 1, all synchronous inputs are ignored and all registers hold their values, including the output register and the pipeline. The cycle latency of R1 and R2 counts only edges with `cke_n` = 0.
- R7: When `ld_n` = 0 and the chip is not selected (`cs1_n` = 1, `cs2` = 0 or `cs3_n` = 1), no command is issued and any burst in progress ends. Transfers that are already in flight still complete. After a deselect, or after a write, `rdata_oe` is low in the matching data cycle.
- R8: When `oe_n` = 1, `rdata_oe` is 0 and `rdata` is all zeros at once, without waiting for a clock edge.
- R9: A read whose array access falls on the same edge as the commit of a write to the same address returns that write's data in each written lane, and the stored data in the other lanes.
- R10: With `ld_n` = 1, the burst advances and the values of `addr` and `rd_wr` are ignored; the direction set at load time is kept. Beat k (k = 0..3, modulo 4) replaces address bits [1:0] with (s+k) mod 4 when `burst_il` = 0, or with s XOR k when `burst_il` = 1, where s is the loaded value of bits [1:0]. An advance with no burst in progress does nothing.
- R11: While `rst_n` is low at a clock edge, the pipeline is cleared, so no transfer is pending afterwards and `rdata_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable |
| ld_n | input | 1 | 0 loads a new command, 1 advances the burst |
| rd_wr | input | 1 | 1 read, 0 write (sampled on load) |
| cs1_n | input | 1 | Active-low chip select |
| cs2 | input | 1 | Active-high chip select |
| cs3_n | input | 1 | Active-low chip select |
| addr | input | ADDR_W (8) | Word address |
| bw_n | input | NBYTE (4) | Active-low byte-lane write enables |
| burst_il | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous active-low output enable |
| wdata | input | 36 | Write data for the write issued two edges earlier |
| rdata | output | 36 | Read data, zero while not valid |
| rdata_oe | output | 1 | Read data valid / bus driven |

## Verification
Three functions can land on the same enabled edge: a write commit in the last pipeline stage, the array access of a read one stage behind it, and possibly a clock-enable stall. The bench forces the first two together by issuing a write and then a read of the same address on the next cycle. It does this once with all byte lanes enabled and once with only the two low lanes enabled. The result is judged by comparing the read word against a value built lane by lane from the new write data and the older stored word. A stall placed between a read command and its data phase shows whether the latency counts only enabled edges.

// File: rtl/zbt_pkg.sv
// Package: shared types and burst ordering for the zero-turnaround SRAM.
// Assumes a fixed four-beat burst; offsets are two bits wide.
package zbt_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_READ  = 1'b1
    } op_e;

    // Offset of burst beat cnt from start offset, linear or interleaved.
    function automatic logic [BEAT_W-1:0] beat_offset(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] cnt,
        input logic              il
    );
        logic [BEAT_W-1:0] lin;
        lin = start + cnt;
        return il ? (start ^ cnt) : lin;
    endfunction

endpackage

// File: rtl/zbt_burst_gen.sv
// Burst address generator: holds the loaded base address and a beat
// counter, and presents the address of the next advance beat.
// Assumes ADDR_W > BEAT_W; state only moves when en is high.
module zbt_burst_gen #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              load,
    input  logic              adv,
    input  logic              il,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] beat_addr
);
    import zbt_pkg::*;

    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] cnt_q;
    logic [BEAT_W-1:0] cnt_nxt;

    assign cnt_nxt = cnt_q + 1'b1;

    // Capture base on load, step the beat counter on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (en) begin
            if (load) begin
                base_q <= start_addr;
                cnt_q  <= '0;
            end else if (adv) begin
                cnt_q <= cnt_nxt;
            end
        end
    end

    assign beat_addr = {base_q[ADDR_W-1:BEAT_W],
                        beat_offset(base_q[BEAT_W-1:0], cnt_nxt, il)};

endmodule

// File: rtl/zbt_cmd_pipe.sv
// Command pipeline: carries issued commands through DEPTH stages so the
// data phase lines up DEPTH enabled edges after the command edge.
// Assumes DEPTH >= 2; exposes stage DEPTH-1 (array read) and DEPTH (commit).
module zbt_cmd_pipe #(
    parameter int ADDR_W = 8,
    parameter int NBYTE  = 4,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              in_vld,
    input  logic              in_wr,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [NBYTE-1:0]  in_bwn,
    output logic              mid_vld,
    output logic              mid_wr,
    output logic [ADDR_W-1:0] mid_addr,
    output logic              tail_vld,
    output logic              tail_wr,
    output logic [ADDR_W-1:0] tail_addr,
    output logic [NBYTE-1:0]  tail_bwn
);
    logic              vld_q  [1:DEPTH];
    logic              wr_q   [1:DEPTH];
    logic [ADDR_W-1:0] addr_q [1:DEPTH];
    logic [NBYTE-1:0]  bwn_q  [1:DEPTH];

    // Valid flags shift on enabled edges and clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 1; i <= DEPTH; i++) vld_q[i] <= 1'b0;
        end else if (en) begin
            vld_q[1] <= in_vld;
            for (int i = 2; i <= DEPTH; i++) vld_q[i] <= vld_q[i-1];
        end
    end

    // Command payload shifts alongside its valid flag.
    always_ff @(posedge clk) begin
        if (en) begin
            wr_q[1]   <= in_wr;
            addr_q[1] <= in_addr;
            bwn_q[1]  <= in_bwn;
            for (int i = 2; i <= DEPTH; i++) begin
                wr_q[i]   <= wr_q[i-1];
                addr_q[i] <= addr_q[i-1];
                bwn_q[i]  <= bwn_q[i-1];
            end
        end
    end

    assign mid_vld   = vld_q[DEPTH-1];
    assign mid_wr    = wr_q[DEPTH-1];
    assign mid_addr  = addr_q[DEPTH-1];
    assign tail_vld  = vld_q[DEPTH];
    assign tail_wr   = wr_q[DEPTH];
    assign tail_addr = addr_q[DEPTH];
    assign tail_bwn  = bwn_q[DEPTH];

endmodule

// File: rtl/zbt_array.sv
// Storage array: one memory per byte lane with a registered read port.
// A read on the same edge as a write to the same address takes each
// written lane from the write data (forwarding). Contents are not reset.
module zbt_array #(
    parameter int ADDR_W = 8,
    parameter int NBYTE  = 4,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    en,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [NBYTE-1:0]        wr_bwn,
    input  logic [NBYTE*BYTE_W-1:0] wr_data,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [NBYTE*BYTE_W-1:0] rd_data
);
    localparam int WORDS = 1 << ADDR_W;

    logic same_addr;
    assign same_addr = (wr_addr == rd_addr);

    for (genvar g = 0; g < NBYTE; g++) begin : g_lane
        logic [BYTE_W-1:0] mem [WORDS];
        logic [BYTE_W-1:0] lane_q;
        logic              lane_we;

        assign lane_we = wr_en && !wr_bwn[g];

        // Commit this lane of the write word.
        always_ff @(posedge clk) begin
            if (en && lane_we) mem[wr_addr] <= wr_data[g*BYTE_W +: BYTE_W];
        end

        // Registered read with per-lane forwarding from the committing write.
        always_ff @(posedge clk) begin
            if (en && rd_en) begin
                lane_q <= (lane_we && same_addr) ? wr_data[g*BYTE_W +: BYTE_W]
                                                 : mem[rd_addr];
            end
        end

        assign rd_data[g*BYTE_W +: BYTE_W] = lane_q;
    end

endmodule

// File: rtl/zbt_sram.sv
// Zero-turnaround pipelined synchronous SRAM (top).
// Decodes load/advance/deselect, feeds a two-stage command pipeline, and
// registers read data so it leaves exactly two enabled edges after the
// command. cke_n freezes all state; oe_n gates the output asynchronously.
module zbt_sram #(
    parameter int ADDR_W = 8,
    parameter int NBYTE  = 4,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cke_n,
    input  logic                    ld_n,
    input  logic                    rd_wr,
    input  logic                    cs1_n,
    input  logic                    cs2,
    input  logic                    cs3_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [NBYTE-1:0]        bw_n,
    input  logic                    burst_il,
    input  logic                    oe_n,
    input  logic [NBYTE*BYTE_W-1:0] wdata,
    output logic [NBYTE*BYTE_W-1:0] rdata,
    output logic                    rdata_oe
);
    import zbt_pkg::*;

    localparam int WORD_W = NBYTE * BYTE_W;
    localparam int PIPE   = 2;

    logic              en;
    logic              sel;
    logic              load_cmd;
    logic              adv_cmd;
    logic              burst_q;
    op_e               burst_op_q;
    logic [ADDR_W-1:0] beat_addr;

    logic              iss_vld;
    op_e               iss_op;
    logic              iss_wr;
    logic [ADDR_W-1:0] iss_addr;
    logic [NBYTE-1:0]  iss_bwn;

    logic              mid_vld;
    logic              mid_wr;
    logic [ADDR_W-1:0] mid_addr;
    logic              tail_vld;
    logic              tail_wr;
    logic [ADDR_W-1:0] tail_addr;
    logic [NBYTE-1:0]  tail_bwn;

    logic [WORD_W-1:0] arr_rd;
    logic              oe_q;
    logic [WORD_W-1:0] dout_q;

    assign en       = !cke_n;
    assign sel      = !cs1_n && cs2 && !cs3_n;
    assign load_cmd = !ld_n && sel;
    assign adv_cmd  = ld_n && burst_q;

    // Track whether a burst is open and which direction it carries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_q    <= 1'b0;
            burst_op_q <= OP_READ;
        end else if (en && !ld_n) begin
            burst_q <= sel;
            if (sel) burst_op_q <= op_e'(rd_wr);
        end
    end

    zbt_burst_gen #(.ADDR_W(ADDR_W)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .load       (load_cmd),
        .adv        (adv_cmd),
        .il         (burst_il),
        .start_addr (addr),
        .beat_addr  (beat_addr)
    );

    // Form the command issued this cycle.
    always_comb begin
        iss_vld  = load_cmd || adv_cmd;
        iss_op   = load_cmd ? op_e'(rd_wr) : burst_op_q;
        iss_wr   = iss_vld && (iss_op == OP_WRITE);
        iss_addr = load_cmd ? addr : beat_addr;
        iss_bwn  = iss_wr ? bw_n : '1;
    end

    zbt_cmd_pipe #(.ADDR_W(ADDR_W), .NBYTE(NBYTE), .DEPTH(PIPE)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .in_vld    (iss_vld),
        .in_wr     (iss_wr),
        .in_addr   (iss_addr),
        .in_bwn    (iss_bwn),
        .mid_vld   (mid_vld),
        .mid_wr    (mid_wr),
        .mid_addr  (mid_addr),
        .tail_vld  (tail_vld),
        .tail_wr   (tail_wr),
        .tail_addr (tail_addr),
        .tail_bwn  (tail_bwn)
    );

    zbt_array #(.ADDR_W(ADDR_W), .NBYTE(NBYTE), .BYTE_W(BYTE_W)) u_array (
        .clk     (clk),
        .en      (en),
        .wr_en   (tail_vld && tail_wr),
        .wr_addr (tail_addr),
        .wr_bwn  (tail_bwn),
        .wr_data (wdata),
        .rd_en   (mid_vld && !mid_wr),
        .rd_addr (mid_addr),
        .rd_data (arr_rd)
    );

    // Output-valid flag: set for exactly the data cycle of a read.
    always_ff @(posedge clk) begin
        if (!rst_n) oe_q <= 1'b0;
        else if (en) oe_q <= tail_vld && !tail_wr;
    end

    // Output data register, loaded only by a read in its data phase.
    always_ff @(posedge clk) begin
        if (en && tail_vld && !tail_wr) dout_q <= arr_rd;
    end

    assign rdata_oe = oe_q && !oe_n;
    assign rdata    = rdata_oe ? dout_q : '0;

endmodule

// File: rtl/zbt_sram_chk.sv
// Checker for zbt_sram: pipeline timing, stall hold, deselect, output gating
// and reset. Bound into every zbt_sram instance below.
module zbt_sram_chk #(
    parameter int WORD_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke_n,
    input logic              ld_n,
    input logic              cs1_n,
    input logic              cs2,
    input logic              cs3_n,
    input logic              oe_n,
    input logic              rdata_oe,
    input logic [WORD_W-1:0] rdata,
    input logic              mid_vld,
    input logic              tail_vld,
    input logic              tail_wr,
    input logic              oe_q,
    input logic [WORD_W-1:0] dout_q
);
    p_pipe_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_n |=> (tail_vld == $past(mid_vld)));

    p_read_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && tail_vld && !tail_wr) |=> oe_q);

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(oe_q) && $stable(dout_q) && $stable(mid_vld)));

    p_desel_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !ld_n && (cs1_n || !cs2 || cs3_n)) |=> !mid_vld);

    p_write_tristate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && tail_vld && tail_wr) |=> !rdata_oe);

    p_oe_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!rdata_oe && rdata == '0));

    p_reset_idle_r11: assert property (@(posedge clk)
        !rst_n |=> (!oe_q && !mid_vld && !tail_vld));

endmodule

bind zbt_sram zbt_sram_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke_n    (cke_n),
    .ld_n     (ld_n),
    .cs1_n    (cs1_n),
    .cs2      (cs2),
    .cs3_n    (cs3_n),
    .oe_n     (oe_n),
    .rdata_oe (rdata_oe),
    .rdata    (rdata),
    .mid_vld  (mid_vld),
    .tail_vld (tail_vld),
    .tail_wr  (tail_wr),
    .oe_q     (oe_q),
    .dout_q   (dout_q)
);

// File: tb/zbt_sram_bench.sv
`timescale 1ns/1ps
module zbt_sram_bench;
    localparam int AW = 8;
    localparam int WW = 36;
    localparam logic [2:0] CS_ON   = 3'b010;  // {cs1_n, cs2, cs3_n}
    localparam logic [2:0] CS_OFF1 = 3'b110;
    localparam logic [2:0] CS_OFF2 = 3'b000;
    localparam logic [2:0] CS_OFF3 = 3'b011;

    localparam logic [WW-1:0] D0  = 36'h123456789;
    localparam logic [WW-1:0] D1  = 36'hABCDEF012;
    localparam logic [WW-1:0] D2  = 36'h0F0F0F0F0;
    localparam logic [WW-1:0] D3  = 36'h987654321;
    localparam logic [WW-1:0] MRG = {D0[35:18], D3[17:0]};

    typedef struct packed {
        logic          cke_n;
        logic          ld_n;
        logic          rd_wr;
        logic          sel;
        logic [AW-1:0] addr;
        logic [3:0]    bw_n;
        logic [WW-1:0] wdata;
        logic          exp_oe;
        logic [WW-1:0] exp_d;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b0, 1'b1, 8'h10, 4'h0, 36'h0, 1'b0, 36'h0},
        '{1'b0, 1'b0, 1'b0, 1'b1, 8'h11, 4'h0, 36'h0, 1'b0, 36'h0},
        '{1'b0, 1'b0, 1'b1, 1'b1, 8'h10, 4'h0, D0,    1'b0, 36'h0},
        '{1'b0, 1'b0, 1'b1, 1'b1, 8'h11, 4'hF, D1,    1'b0, 36'h0},
        '{1'b0, 1'b0, 1'b0, 1'b1, 8'h12, 4'h0, 36'h0, 1'b1, D0},
        '{1'b0, 1'b0, 1'b1, 1'b1, 8'h12, 4'h0, 36'h0, 1'b1, D1},
        '{1'b0, 1'b0, 1'b0, 1'b1, 8'h10, 4'hC, D2,    1'b0, 36'h0},
        '{1'b0, 1'b0, 1'b1, 1'b1, 8'h10, 4'h0, 36'h0, 1'b1, D2},
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 4'hF, D3,    1'b0, 36'h0},
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 4'hF, 36'h0, 1'b1, MRG},
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 4'hF, 36'h0, 1'b0, 36'h0},
        '{1'b1, 1'b0, 1'b1, 1'b1, 8'h11, 4'h0, 36'h0, 1'b0, 36'h0},
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 4'hF, 36'h0, 1'b0, 36'h0},
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 4'hF, 36'h0, 1'b0, 36'h0}
    };

    logic          clk = 1'b0;
    logic          rst_n, cke_n, ld_n, rd_wr, cs1_n, cs2, cs3_n, burst_il, oe_n;
    logic [AW-1:0] addr;
    logic [3:0]    bw_n;
    logic [WW-1:0] wdata;
    logic [WW-1:0] rdata;
    logic          rdata_oe;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    zbt_sram u_zbt_sram (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ld_n(ld_n), .rd_wr(rd_wr),
        .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .addr(addr), .bw_n(bw_n),
        .burst_il(burst_il), .oe_n(oe_n), .wdata(wdata), .rdata(rdata),
        .rdata_oe(rdata_oe)
    );

    task automatic drive(input logic c_n, input logic l_n, input logic rw,
                         input logic [2:0] cs, input logic [AW-1:0] a,
                         input logic [3:0] b, input logic [WW-1:0] d);
        cke_n = c_n; ld_n = l_n; rd_wr = rw;
        {cs1_n, cs2, cs3_n} = cs;
        addr = a; bw_n = b; wdata = d;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic exp_oe, input logic [WW-1:0] exp_d);
        checks++;
        if (rdata_oe !== exp_oe || (exp_oe && rdata !== exp_d) ||
            (!exp_oe && rdata !== '0)) begin
            errors++;
            $display("FAIL %s: actual oe=%0b data=%h expected oe=%0b data=%h",
                     tag, rdata_oe, rdata, exp_oe, exp_oe ? exp_d : '0);
        end
    endtask

    function automatic string row_tag(input int i);
        case (i)
            4, 5:       return "R2 R3 alternate";
            6, 8:       return "R7 write tristate";
            7:          return "R9 forward full word";
            9:          return "R4 R9 lane merge";
            10:         return "R7 deselect";
            11, 12, 13: return "R6 stalled command ignored";
            default:    return "R1 table";
        endcase
    endfunction

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R11 watchdog: actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; oe_n = 1'b0; burst_il = 1'b0;
        drive(1'b0, 1'b0, 1'b1, CS_OFF2, '0, 4'hF, '0);
        repeat (3) tick();
        check("R11 reset idle", 1'b0, '0);
        rst_n = 1'b1;

        // Table walk: alternation, lane writes, forwarding, stall.
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].cke_n, VEC[i].ld_n, VEC[i].rd_wr,
                  VEC[i].sel ? CS_ON : CS_OFF2, VEC[i].addr, VEC[i].bw_n, VEC[i].wdata);
            tick();
            check(row_tag(i), VEC[i].exp_oe, VEC[i].exp_d);
        end

        // R6: stall between a read command and its data phase.
        drive(1'b0, 1'b0, 1'b1, CS_ON, 8'h10, 4'h0, '0); tick();
        check("R6 before stall", 1'b0, '0);
        for (int k = 0; k < 3; k++) begin
            drive(1'b1, 1'b0, 1'b0, CS_ON, 8'h10, 4'h0, '0); tick();
            check("R6 stalled edge", 1'b0, '0);
        end
        drive(1'b0, 1'b0, 1'b1, CS_OFF2, '0, 4'hF, '0); tick();
        check("R6 one enabled edge", 1'b0, '0);
        tick();
        check("R6 R2 read after stall", 1'b1, MRG);
        drive(1'b1, 1'b0, 1'b1, CS_OFF2, '0, 4'hF, '0); tick();
        check("R6 output held", 1'b1, MRG);
        oe_n = 1'b1; #1;
        check("R8 async oe high", 1'b0, '0);
        oe_n = 1'b0; #1;
        check("R8 async oe low", 1'b1, MRG);
        drive(1'b0, 1'b0, 1'b1, CS_OFF2, '0, 4'hF, '0); tick();
        check("R2 R7 single valid cycle", 1'b0, '0);

        // R5 R6: word 0x10 untouched by read byte enables and stalled writes.
        drive(1'b0, 1'b0, 1'b1, CS_ON, 8'h10, 4'h0, '0); tick();
        drive(1'b0, 1'b0, 1'b1, CS_OFF2, '0, 4'hF, '0); tick(); tick();
        check("R5 R6 word unchanged", 1'b1, MRG);

        // R10: linear write burst from 0x22, advance ignores rd_wr and addr.
        burst_il = 1'b0;
        drive(1'b0, 1'b0, 1'b0, CS_ON, 8'h22, 4'h0, '0); tick();
        drive(1'b0, 1'b1, 1'b1, CS_OFF2, 8'hFF, 4'h0, '0); tick();
        drive(1'b0, 1'b1, 1'b1, CS_OFF2, 8'hFF, 4'h0, 36'h100); tick();
        check("R10 write beat", 1'b0, '0);
        drive(1'b0, 1'b1, 1'b1, CS_OFF2, 8'hFF, 4'h0, 36'h101); tick();
        // Interleaved read burst from 0x21.
        burst_il = 1'b1;
        drive(1'b0, 1'b0, 1'b1, CS_ON, 8'h21, 4'hF, 36'h102); tick();
        drive(1'b0, 1'b1, 1'b0, CS_OFF2, 8'h00, 4'h0, 36'h103); tick();
        drive(1'b0, 1'b1, 1'b0, CS_OFF2, 8'h00, 4'h0, '0); tick();
        check("R10 R9 beat 0x21", 1'b1, 36'h103);
        tick();
        check("R10 beat 0x20", 1'b1, 36'h102);
        drive(1'b0, 1'b0, 1'b1, CS_OFF2, '0, 4'hF, '0); tick();
        check("R10 beat 0x23", 1'b1, 36'h101);
        tick();
        check("R10 beat 0x22", 1'b1, 36'h100);
        tick();
        check("R7 tristate after deselect", 1'b0, '0);
        drive(1'b0, 1'b1, 1'b1, CS_ON, 8'h10, 4'hF, '0); tick(); tick();
        check("R10 advance without burst", 1'b0, '0);
        tick();
        check("R10 advance without burst", 1'b0, '0);

        // R7: deselect via cs1_n ends a burst; in-flight read completes.
        drive(1'b0, 1'b0, 1'b1, CS_ON, 8'h20, 4'hF, '0); tick();
        drive(1'b0, 1'b0, 1'b1, CS_OFF1, 8'h20, 4'hF, '0); tick();
        drive(1'b0, 1'b1, 1'b1, CS_ON, 8'h20, 4'hF, '0); tick();
        check("R7 in-flight read completes", 1'b1, 36'h102);
        tick();
        check("R7 cs1_n deselect", 1'b0, '0);
        tick();
        check("R7 burst ended", 1'b0, '0);

        // R7: same with cs3_n.
        drive(1'b0, 1'b0, 1'b1, CS_ON, 8'h23, 4'hF, '0); tick();
        drive(1'b0, 1'b0, 1'b1, CS_OFF3, 8'h23, 4'hF, '0); tick();
        drive(1'b0, 1'b1, 1'b1, CS_ON, 8'h23, 4'hF, '0); tick();
        check("R7 in-flight read cs3_n", 1'b1, 36'h101);
        tick();
        check("R7 cs3_n deselect", 1'b0, '0);
        tick();
        check("R7 cs3_n burst ended", 1'b0, '0);

        // R11: reset drops a pending read.
        drive(1'b0, 1'b0, 1'b1, CS_ON, 8'h10, 4'hF, '0); tick();
        rst_n = 1'b0;
        drive(1'b0, 1'b0, 1'b1, CS_OFF2, '0, 4'hF, '0); tick();
        check("R11 reset clears", 1'b0, '0);
        rst_n = 1'b1; tick();
        check("R11 no pending read", 1'b0, '0);
        tick();
        check("R11 no pending read", 1'b0, '0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule